// File: doc/BRIEF.md
# Wide-to-Narrow Bus Width Converter

This block joins one Wishbone initiator port to one Wishbone subordinate port whose data bus is narrower by an integer ratio. An initiator access is taken in one clock, then split into a run of narrow subordinate accesses called beats, one per narrow word that has at least one live select lane. Each beat carries its own slice of the write data and of the select lanes. Read data from every beat is collected in a wide holding register, and the initiator gets a single acknowledge after the last live beat.

Both sides may be classic or pipelined, chosen by parameter. A pipelined initiator sees stall while the converter is busy. A pipelined subordinate gets exactly one strobe per beat, and the converter then waits for the response with the strobe masked. Optional signals the initiator lacks go to the subordinate at safe defaults. Response flags the subordinate lacks read as zero.

The controller is a four-state machine. IDLE takes a request (transition START to ISSUE, or SKIP_ALL to RESP when no lane is live). ISSUE drives the strobe. ACCEPT moves it to WAIT on a pipelined subordinate. A response in the waiting state either begins the next live beat (NEXT, back to ISSUE) or ends the run (LAST or FAULT, to RESP). RESP gives one response cycle and returns to IDLE (RETIRE). Loss of the initiator cycle in ISSUE or WAIT takes ABORT to IDLE.

Top module: `wbw_conv`

## Requirements
- R1: The initiator data width is BEATS times the subordinate data width, with BEATS at least 2. The subordinate address is log2(BEATS) bits wider, so both ports span the same number of bits. The subordinate granularity must not exceed the initiator granularity. Each initiator select bit drives G = I_GRAN/S_GRAN adjacent subordinate-granularity lanes. For example, with 16-bit initiator and 8-bit subordinate granularity, initiator select bit k enables beats 2k and 2k+1 on an 8-bit subordinate.
- R2: Beats run from the least significant narrow word upward. The subordinate address of beat b is {initiator address, b}, with b in the low log2(BEATS) bits. The beat writes data bits [b*S_DW +: S_DW] with its own slice of the expanded select.
- R3: A beat whose select slice is all zero is never issued. A request with every select bit zero is acknowledged one clock after it is taken, with no subordinate cycle.
- R4: Read data from each beat lands in its slice of the holding register, which is cleared when a request is taken. The whole register appears on the initiator read-data bus in the acknowledge cycle, so skipped slices read as zero.
- R5: An error or retry response on any beat ends the run at once. No later beat is issued, that response goes to the initiator for one cycle, and no acknowledge is given.
- R6: If the initiator drops cyc while beats are outstanding, the converter returns to IDLE. The subordinate cyc and stb are low one clock later, and no response is given for that request.
- R7: With a pipelined initiator (I_PIPE=1), stall is high whenever cyc is high and the converter is not idle. With a classic initiator, stall stays 0.
- R8: With a pipelined subordinate (S_PIPE=1), the strobe for a beat is held only until the subordinate does not stall, and it stays masked until that beat's response arrives. Each beat is therefore accepted exactly once.
- R9: With I_TAGS=0, the subordinate gets lock 0, cycle type 3'b000 (classic) and burst type 2'b00 (linear), whatever the initiator drives. With I_TAGS=1, the three pass through unchanged.
- R10: With S_FAULTS=0, the subordinate's error and retry inputs are ignored, and the initiator error and retry outputs stay 0.
- R11: While beats are being issued, the subordinate cyc is high and the subordinate write enable equals the initiator write enable taken with the request. The idle state after reset drives no subordinate cycle and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_cyc | input | 1 | Initiator bus cycle valid |
| i_stb | input | 1 | Initiator strobe |
| i_we | input | 1 | Initiator write enable |
| i_adr | input | I_AW | Initiator word address |
| i_sel | input | I_DW/I_GRAN | Initiator select lanes |
| i_dat_w | input | I_DW | Initiator write data |
| i_dat_r | output | I_DW | Gathered read data, valid with acknowledge |
| i_ack | output | 1 | Initiator acknowledge |
| i_err | output | 1 | Initiator error response |
| i_rty | output | 1 | Initiator retry response |
| i_stall | output | 1 | Initiator stall (pipelined initiator only) |
| i_lock | input | 1 | Initiator lock request |
| i_cti | input | 3 | Initiator cycle type |
| i_bte | input | 2 | Initiator burst type |
| s_cyc | output | 1 | Subordinate bus cycle valid |
| s_stb | output | 1 | Subordinate strobe |
| s_we | output | 1 | Subordinate write enable |
| s_adr | output | I_AW+log2(BEATS) | Subordinate word address |
| s_sel | output | S_DW/S_GRAN | Subordinate select lanes |
| s_dat_w | output | S_DW | Subordinate write data |
| s_dat_r | input | S_DW | Subordinate read data |
| s_ack | input | 1 | Subordinate acknowledge |
| s_err | input | 1 | Subordinate error response |
| s_rty | input | 1 | Subordinate retry response |
| s_stall | input | 1 | Subordinate stall (pipelined subordinate only) |
| s_lock | output | 1 | Subordinate lock |
| s_cti | output | 3 | Subordinate cycle type |
| s_bte | output | 2 | Subordinate burst type |

## Verification
The assertions check on every cycle that a strobe always comes with a cycle and a live select slice, and that at most one response flag is raised. They also check that a pipelined subordinate never sees a second strobe for an accepted beat, that stall covers a busy pipelined initiator, and that a dropped initiator cycle clears the subordinate side one clock later. Only the bench scenarios can show the beat order and addresses, the number of beats issued, the gathered read data and the granularity expansion against a memory model. The same holds for the early end of a run on error or retry and the default and pass-through values of the optional signals.

// File: rtl/wbw_pkg.sv
package wbw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } wbw_state_e;

    typedef enum logic [1:0] {
        RSP_ACK = 2'd0,
        RSP_ERR = 2'd1,
        RSP_RTY = 2'd2
    } wbw_resp_e;

    localparam logic [2:0] CTI_CLASSIC = 3'b000;
    localparam logic [1:0] BTE_LINEAR  = 2'b00;
endpackage

// File: rtl/wbw_sel_expand.sv
// Widens initiator select lanes to subordinate granularity (R1).
module wbw_sel_expand #(
    parameter int I_SELW = 4,
    parameter int G      = 1
) (
    input  logic [I_SELW-1:0]   sel_in,
    output logic [I_SELW*G-1:0] sel_out
);
    for (genvar k = 0; k < I_SELW; k++) begin : g_lane
        assign sel_out[k*G +: G] = {G{sel_in[k]}};
    end
endmodule

// File: rtl/wbw_beat_pick.sv
// Finds the lowest beat at or above 'from' whose select slice is live (R2, R3).
module wbw_beat_pick #(
    parameter int BEATS = 4,
    parameter int LANES = 1,
    parameter int BIW   = 2
) (
    input  logic [BEATS*LANES-1:0] sel,
    input  logic [BIW:0]           from,
    output logic                   found,
    output logic [BIW-1:0]         idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int b = BEATS - 1; b >= 0; b--) begin
            if ((BIW+1)'(b) >= from && (|sel[b*LANES +: LANES])) begin
                found = 1'b1;
                idx   = BIW'(b);
            end
        end
    end
endmodule

// File: rtl/wbw_conv.sv
module wbw_conv
    import wbw_pkg::*;
#(
    parameter int I_AW     = 4,
    parameter int I_DW     = 32,
    parameter int S_DW     = 8,
    parameter int I_GRAN   = 8,
    parameter int S_GRAN   = 8,
    parameter int I_PIPE   = 0,
    parameter int S_PIPE   = 1,
    parameter int I_TAGS   = 0,
    parameter int S_FAULTS = 1,
    localparam int BEATS   = I_DW / S_DW,
    localparam int BIW     = $clog2(BEATS),
    localparam int S_AW    = I_AW + BIW,
    localparam int I_SELW  = I_DW / I_GRAN,
    localparam int S_SELW  = S_DW / S_GRAN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_cyc,
    input  logic              i_stb,
    input  logic              i_we,
    input  logic [I_AW-1:0]   i_adr,
    input  logic [I_SELW-1:0] i_sel,
    input  logic [I_DW-1:0]   i_dat_w,
    output logic [I_DW-1:0]   i_dat_r,
    output logic              i_ack,
    output logic              i_err,
    output logic              i_rty,
    output logic              i_stall,
    input  logic              i_lock,
    input  logic [2:0]        i_cti,
    input  logic [1:0]        i_bte,
    output logic              s_cyc,
    output logic              s_stb,
    output logic              s_we,
    output logic [S_AW-1:0]   s_adr,
    output logic [S_SELW-1:0] s_sel,
    output logic [S_DW-1:0]   s_dat_w,
    input  logic [S_DW-1:0]   s_dat_r,
    input  logic              s_ack,
    input  logic              s_err,
    input  logic              s_rty,
    input  logic              s_stall,
    output logic              s_lock,
    output logic [2:0]        s_cti,
    output logic [1:0]        s_bte
);
    localparam int G     = I_GRAN / S_GRAN;
    localparam int XSELW = I_SELW * G;

    // R1: parameter legality
    if (S_DW * BEATS != I_DW || BEATS < 2 || S_GRAN > I_GRAN || XSELW != BEATS * S_SELW) begin : g_bad_cfg
        $error("wbw_conv: illegal width or granularity parameters");
    end

    wbw_state_e          state_q, state_d;
    wbw_resp_e           resp_q, resp_d;
    logic [BIW-1:0]      beat_q, beat_d;
    logic [I_AW-1:0]     adr_q;
    logic                we_q;
    logic [I_DW-1:0]     wdat_q;
    logic [XSELW-1:0]    selx_q;
    logic [I_DW-1:0]     hold_q;

    logic [XSELW-1:0]    selx_in;
    logic [XSELW-1:0]    pick_sel;
    logic [BIW:0]        pick_from;
    logic                pick_found;
    logic [BIW-1:0]      pick_idx;

    logic req_start, f_err, f_rty, beat_end, resp_seen, stall_in;

    wbw_sel_expand #(.I_SELW(I_SELW), .G(G)) u_expand (
        .sel_in  (i_sel),
        .sel_out (selx_in)
    );

    wbw_beat_pick #(.BEATS(BEATS), .LANES(S_SELW), .BIW(BIW)) u_pick (
        .sel   (pick_sel),
        .from  (pick_from),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        req_start = (state_q == ST_IDLE) && i_cyc && i_stb;
        pick_sel  = (state_q == ST_IDLE) ? selx_in : selx_q;
        pick_from = (state_q == ST_IDLE) ? '0 : ((BIW+1)'(beat_q) + (BIW+1)'(1));
        f_err     = s_err && (S_FAULTS != 0);
        f_rty     = s_rty && (S_FAULTS != 0);
        stall_in  = s_stall && (S_PIPE != 0);
        beat_end  = s_ack || f_err || f_rty;
        resp_seen = beat_end && i_cyc &&
                    ((S_PIPE != 0) ? (state_q == ST_WAIT) : (state_q == ST_ISSUE));
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        resp_d  = resp_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_start) begin
                    if (pick_found) begin        // START
                        state_d = ST_ISSUE;
                        beat_d  = pick_idx;
                    end else begin               // SKIP_ALL
                        state_d = ST_RESP;
                        resp_d  = RSP_ACK;
                    end
                end
            end
            ST_ISSUE, ST_WAIT: begin
                if (!i_cyc) begin                // ABORT
                    state_d = ST_IDLE;
                end else if (state_q == ST_ISSUE && S_PIPE != 0) begin
                    if (!stall_in) state_d = ST_WAIT;   // ACCEPT
                end else if (resp_seen) begin
                    if (f_err) begin             // FAULT
                        state_d = ST_RESP;
                        resp_d  = RSP_ERR;
                    end else if (f_rty) begin    // FAULT
                        state_d = ST_RESP;
                        resp_d  = RSP_RTY;
                    end else if (pick_found) begin  // NEXT
                        state_d = ST_ISSUE;
                        beat_d  = pick_idx;
                    end else begin               // LAST
                        state_d = ST_RESP;
                        resp_d  = RSP_ACK;
                    end
                end
            end
            ST_RESP: state_d = ST_IDLE;          // RETIRE
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            resp_q  <= RSP_ACK;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            resp_q  <= resp_d;
        end
    end

    // Request capture and read gathering
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_q  <= '0;
            we_q   <= 1'b0;
            wdat_q <= '0;
            selx_q <= '0;
            hold_q <= '0;
        end else if (req_start) begin
            adr_q  <= i_adr;
            we_q   <= i_we;
            wdat_q <= i_dat_w;
            selx_q <= selx_in;
            hold_q <= '0;
        end else if (resp_seen && s_ack && !f_err && !f_rty && !we_q) begin
            hold_q[beat_q*S_DW +: S_DW] <= s_dat_r;
        end
    end

    // Outputs
    always_comb begin
        s_cyc   = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
        s_stb   = (state_q == ST_ISSUE);
        s_we    = we_q;
        s_adr   = {adr_q, beat_q};
        s_sel   = selx_q[beat_q*S_SELW +: S_SELW];
        s_dat_w = wdat_q[beat_q*S_DW +: S_DW];
        i_ack   = (state_q == ST_RESP) && (resp_q == RSP_ACK);
        i_err   = (state_q == ST_RESP) && (resp_q == RSP_ERR);
        i_rty   = (state_q == ST_RESP) && (resp_q == RSP_RTY);
        i_dat_r = i_ack ? hold_q : '0;
        i_stall = (I_PIPE != 0) && i_cyc && (state_q != ST_IDLE);
        if (I_TAGS != 0) begin
            s_lock = i_lock;
            s_cti  = i_cti;
            s_bte  = i_bte;
        end else begin
            s_lock = 1'b0;
            s_cti  = CTI_CLASSIC;
            s_bte  = BTE_LINEAR;
        end
    end

    // Assertions
    a_r11_stb_in_cyc: assert property (@(posedge clk) disable iff (!rst_n)
        s_stb |-> s_cyc);

    a_r3_live_slice: assert property (@(posedge clk) disable iff (!rst_n)
        s_stb |-> (|s_sel));

    a_r5_single_resp: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({i_ack, i_err, i_rty}));

    a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (s_cyc && !i_cyc) |=> (!s_cyc && !s_stb));

    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (S_PIPE != 0 && s_stb && !s_stall) |=> !s_stb);

    a_r7_busy_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (I_PIPE != 0 && i_cyc && s_cyc) |-> i_stall);

    a_r10_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (S_FAULTS == 0) |-> (!i_err && !i_rty));
endmodule

// File: tb/tb_wbw_conv.sv
`timescale 1ns/1ps
module tb_wbw_conv;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- DUT A: classic initiator, pipelined subordinate, faults on
    logic        a_cyc = 0, a_stb = 0, a_we = 0, a_lock = 0;
    logic [3:0]  a_adr = 0, a_sel = 0;
    logic [31:0] a_dw = 0, a_dr;
    logic [2:0]  a_cti = 0, as_cti;
    logic [1:0]  a_bte = 0, as_bte;
    logic        a_ack, a_err, a_rty, a_stall;
    logic        as_cyc, as_stb, as_we, as_lock;
    logic [5:0]  as_adr;
    logic [0:0]  as_sel;
    logic [7:0]  as_dw, as_dr;
    logic        as_ack, as_err, as_rty, as_stall;

    wbw_conv #(.I_AW(4), .I_DW(32), .S_DW(8), .I_GRAN(8), .S_GRAN(8),
               .I_PIPE(0), .S_PIPE(1), .I_TAGS(0), .S_FAULTS(1)) dut (
        .clk(clk), .rst_n(rst_n),
        .i_cyc(a_cyc), .i_stb(a_stb), .i_we(a_we), .i_adr(a_adr), .i_sel(a_sel),
        .i_dat_w(a_dw), .i_dat_r(a_dr), .i_ack(a_ack), .i_err(a_err), .i_rty(a_rty),
        .i_stall(a_stall), .i_lock(a_lock), .i_cti(a_cti), .i_bte(a_bte),
        .s_cyc(as_cyc), .s_stb(as_stb), .s_we(as_we), .s_adr(as_adr), .s_sel(as_sel),
        .s_dat_w(as_dw), .s_dat_r(as_dr), .s_ack(as_ack), .s_err(as_err), .s_rty(as_rty),
        .s_stall(as_stall), .s_lock(as_lock), .s_cti(as_cti), .s_bte(as_bte));

    localparam logic [5:0] ERR_ADR = 6'h3A; // initiator word 14, beat 2
    localparam logic [5:0] RTY_ADR = 6'h2D; // initiator word 11, beat 1

    logic [7:0] mem_a [0:63];
    logic [7:0] ref_a [0:63];
    logic [5:0] log_a [0:255];
    int tot_a;

    // Pipelined subordinate model with random stall
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem_a[i] <= 8'(i * 7 + 3);
            as_ack <= 0; as_err <= 0; as_rty <= 0; as_stall <= 0; as_dr <= 0; tot_a <= 0;
        end else begin
            as_stall <= ($urandom % 3) == 0;
            as_ack <= 0; as_err <= 0; as_rty <= 0;
            if (as_cyc && as_stb && !as_stall) begin
                log_a[tot_a[7:0]] <= as_adr;
                tot_a <= tot_a + 1;
                if (as_adr == ERR_ADR) as_err <= 1;
                else if (as_adr == RTY_ADR) as_rty <= 1;
                else begin
                    as_ack <= 1;
                    as_dr  <= mem_a[as_adr];
                    if (as_we && as_sel[0]) mem_a[as_adr] <= as_dw;
                end
            end
        end
    end

    // ---------------- DUT B: pipelined initiator, classic subordinate, 16-bit initiator lanes
    logic        b_cyc = 0, b_stb = 0, b_we = 0, b_lock = 0;
    logic [3:0]  b_adr = 0;
    logic [1:0]  b_sel = 0;
    logic [31:0] b_dw = 0, b_dr;
    logic [2:0]  b_cti = 0, bs_cti;
    logic [1:0]  b_bte = 0, bs_bte;
    logic        b_ack, b_err, b_rty, b_stall;
    logic        bs_cyc, bs_stb, bs_we, bs_lock;
    logic [5:0]  bs_adr;
    logic [0:0]  bs_sel;
    logic [7:0]  bs_dw, bs_dr;
    logic        bs_ack;

    wbw_conv #(.I_AW(4), .I_DW(32), .S_DW(8), .I_GRAN(16), .S_GRAN(8),
               .I_PIPE(1), .S_PIPE(0), .I_TAGS(1), .S_FAULTS(0)) dut_b (
        .clk(clk), .rst_n(rst_n),
        .i_cyc(b_cyc), .i_stb(b_stb), .i_we(b_we), .i_adr(b_adr), .i_sel(b_sel),
        .i_dat_w(b_dw), .i_dat_r(b_dr), .i_ack(b_ack), .i_err(b_err), .i_rty(b_rty),
        .i_stall(b_stall), .i_lock(b_lock), .i_cti(b_cti), .i_bte(b_bte),
        .s_cyc(bs_cyc), .s_stb(bs_stb), .s_we(bs_we), .s_adr(bs_adr), .s_sel(bs_sel),
        .s_dat_w(bs_dw), .s_dat_r(bs_dr), .s_ack(bs_ack), .s_err(1'b1), .s_rty(1'b1),
        .s_stall(1'b1), .s_lock(bs_lock), .s_cti(bs_cti), .s_bte(bs_bte));

    logic [7:0] mem_b [0:63];
    logic [7:0] ref_b [0:63];
    logic [5:0] log_b [0:255];
    int tot_b;

    // Classic subordinate model: acknowledge one clock after strobe
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) mem_b[i] <= 8'(i * 5 + 11);
            bs_ack <= 0; bs_dr <= 0; tot_b <= 0;
        end else begin
            bs_ack <= 0;
            if (bs_cyc && bs_stb && !bs_ack) begin
                bs_ack <= 1;
                bs_dr  <= mem_b[bs_adr];
                log_b[tot_b[7:0]] <= bs_adr;
                tot_b <= tot_b + 1;
                if (bs_we && bs_sel[0]) mem_b[bs_adr] <= bs_dw;
            end
        end
    end

    // ---------------- reference helpers
    function automatic logic [3:0] beat_mask(input int g, input logic [3:0] sel);
        logic [3:0] m;
        for (int b = 0; b < 4; b++) m[b] = sel[b / g];
        return m;
    endfunction

    function automatic logic [31:0] exp_rd(input bit on_b, input logic [3:0] adr, input logic [3:0] m);
        logic [31:0] r = '0;
        for (int b = 0; b < 4; b++)
            if (m[b]) r[b*8 +: 8] = on_b ? ref_b[{adr, 2'(b)}] : ref_a[{adr, 2'(b)}];
        return r;
    endfunction

    // kind: 0 ack, 1 err, 2 rty, 3 timeout
    task automatic run_a(input logic [3:0] adr, input logic we, input logic [3:0] sel,
                         input logic [31:0] dw, output logic [31:0] dr, output int kind,
                         output int st, output int nacc);
        int n = 0;
        @(negedge clk);
        st = tot_a;
        a_adr = adr; a_we = we; a_sel = sel; a_dw = dw; a_cyc = 1; a_stb = 1;
        @(negedge clk);
        if (sel != 0 && !(a_ack | a_err | a_rty)) begin
            check(as_cyc == 1'b1, "R11 s_cyc during run", 32'(as_cyc), 1);
            check(as_we == we, "R11 s_we follows request", 32'(as_we), 32'(we));
        end
        while (!(a_ack | a_err | a_rty) && n < 60) begin
            @(negedge clk);
            n++;
        end
        kind = a_ack ? 0 : a_err ? 1 : a_rty ? 2 : 3;
        dr = a_dr;
        a_cyc = 0; a_stb = 0;
        nacc = tot_a - st;
    endtask

    task automatic run_b(input logic [3:0] adr, input logic we, input logic [1:0] sel,
                         input logic [31:0] dw, output logic [31:0] dr, output int kind,
                         output int st, output int nacc);
        int n = 0;
        @(negedge clk);
        st = tot_b;
        b_adr = adr; b_we = we; b_sel = sel; b_dw = dw; b_cyc = 1; b_stb = 1;
        @(negedge clk);
        b_stb = 0;
        check(b_stall == 1'b1, "R7 stall while busy", 32'(b_stall), 1);
        while (!(b_ack | b_err | b_rty) && n < 60) begin
            @(negedge clk);
            n++;
        end
        kind = b_ack ? 0 : b_err ? 1 : b_rty ? 2 : 3;
        dr = b_dr;
        b_cyc = 0;
        @(negedge clk);
        check(b_stall == 1'b0, "R7 stall clear when idle", 32'(b_stall), 0);
        nacc = tot_b - st;
    endtask

    // Checks beat count, order, addresses, read data; updates reference on writes
    task automatic verify(input bit on_b, input logic [3:0] adr, input logic we,
                          input logic [3:0] m, input logic [31:0] dw, input logic [31:0] dr,
                          input int kind, input int st, input int nacc);
        int k = 0;
        check(kind == 0, "R10/R2 completes with ack", 32'(kind), 0);
        check(nacc == $countones(m), "R3 beats issued", 32'(nacc), 32'($countones(m)));
        for (int b = 0; b < 4; b++) begin
            if (m[b]) begin
                logic [5:0] got;
                got = on_b ? log_b[8'(st + k)] : log_a[8'(st + k)];
                check(got == {adr, 2'(b)}, "R2 beat address order", 32'(got), 32'({adr, 2'(b)}));
                k++;
            end
        end
        if (!we)
            check(dr == exp_rd(on_b, adr, m), "R4 gathered read", dr, exp_rd(on_b, adr, m));
        else
            for (int b = 0; b < 4; b++)
                if (m[b]) begin
                    if (on_b) ref_b[{adr, 2'(b)}] = dw[b*8 +: 8];
                    else      ref_a[{adr, 2'(b)}] = dw[b*8 +: 8];
                end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails + 1);
        $finish;
    end

    initial begin
        logic [31:0] dr;
        int kind, st, nacc;
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) begin
            ref_a[i] = 8'(i * 7 + 3);
            ref_b[i] = 8'(i * 5 + 11);
        end
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state
        check(as_cyc == 0 && as_stb == 0, "R11 reset: no subordinate cycle", {as_cyc, as_stb}, 0);
        check(a_ack == 0 && a_err == 0 && a_rty == 0, "R11 reset: no response", {a_ack, a_err, a_rty}, 0);
        check(bs_cyc == 0 && b_stall == 0, "R7 reset: idle, no stall", {bs_cyc, b_stall}, 0);

        // Optional signal defaults and pass-through
        a_lock = 1; a_cti = 3'b111; a_bte = 2'b11;
        b_lock = 1; b_cti = 3'b010; b_bte = 2'b01;
        @(negedge clk);
        check(as_lock == 0 && as_cti == 3'b000 && as_bte == 2'b00, "R9 defaults",
              {as_lock, as_cti, as_bte}, 0);
        check(bs_lock == 1 && bs_cti == 3'b010 && bs_bte == 2'b01, "R9 pass-through",
              {bs_lock, bs_cti, bs_bte}, {26'd0, 1'b1, 3'b010, 2'b01});

        // Directed: full write and read back on A
        run_a(4'd3, 1, 4'hF, 32'hDEADBEEF, dr, kind, st, nacc);
        verify(0, 4'd3, 1, 4'hF, 32'hDEADBEEF, dr, kind, st, nacc);
        run_a(4'd3, 0, 4'hF, 0, dr, kind, st, nacc);
        verify(0, 4'd3, 0, 4'hF, 0, dr, kind, st, nacc);
        check(dr == 32'hDEADBEEF, "R4 read-back full word", dr, 32'hDEADBEEF);

        // Partial select: skipped beats not issued, read slices zero
        run_a(4'd4, 1, 4'b0101, 32'h11223344, dr, kind, st, nacc);
        verify(0, 4'd4, 1, 4'b0101, 32'h11223344, dr, kind, st, nacc);
        run_a(4'd4, 0, 4'b1010, 0, dr, kind, st, nacc);
        verify(0, 4'd4, 0, 4'b1010, 0, dr, kind, st, nacc);
        run_a(4'd4, 0, 4'b1111, 0, dr, kind, st, nacc);
        verify(0, 4'd4, 0, 4'b1111, 0, dr, kind, st, nacc);

        // All-zero select: ack with no subordinate cycle
        run_a(4'd6, 0, 4'b0000, 0, dr, kind, st, nacc);
        check(kind == 0 && nacc == 0, "R3 zero select acked without beats", 32'(nacc), 0);
        check(dr == 0, "R4 zero select reads zero", dr, 0);

        // Error on beat 2 of word 14, retry on beat 1 of word 11
        run_a(4'd14, 0, 4'hF, 0, dr, kind, st, nacc);
        check(kind == 1, "R5 error passed through", 32'(kind), 1);
        check(nacc == 3, "R5 run stops at failing beat", 32'(nacc), 3);
        run_a(4'd11, 0, 4'hF, 0, dr, kind, st, nacc);
        check(kind == 2, "R5 retry passed through", 32'(kind), 2);
        check(nacc == 2, "R5 run stops at retried beat", 32'(nacc), 2);

        // Abort: drop cyc after the request is taken
        @(negedge clk);
        a_adr = 4'd5; a_we = 0; a_sel = 4'hF; a_cyc = 1; a_stb = 1;
        @(negedge clk);
        a_cyc = 0; a_stb = 0;
        @(negedge clk);
        check(as_cyc == 0 && as_stb == 0, "R6 subordinate idle after abort", {as_cyc, as_stb}, 0);
        begin
            int seen = 0;
            for (int i = 0; i < 6; i++) begin
                if (a_ack | a_err | a_rty) seen++;
                @(negedge clk);
            end
            check(seen == 0, "R6 no response after abort", 32'(seen), 0);
        end

        // B: granularity expansion, err/rty inputs tied high are ignored
        run_b(4'd2, 1, 2'b01, 32'hCAFE_BABE, dr, kind, st, nacc);
        verify(1, 4'd2, 1, beat_mask(2, 4'b0001), 32'hCAFE_BABE, dr, kind, st, nacc);
        check(nacc == 2, "R1 one lane drives two beats", 32'(nacc), 2);
        run_b(4'd2, 0, 2'b11, 0, dr, kind, st, nacc);
        verify(1, 4'd2, 0, 4'hF, 0, dr, kind, st, nacc);
        check(dr[15:0] == 16'hBABE, "R1 lane data in low half", 32'(dr[15:0]), 32'hBABE);
        run_b(4'd9, 0, 2'b10, 0, dr, kind, st, nacc);
        verify(1, 4'd9, 0, beat_mask(2, 4'b0010), 0, dr, kind, st, nacc);
        check(b_err == 0 && b_rty == 0, "R10 no fault outputs", {b_err, b_rty}, 0);

        // Constrained random on both
        for (int t = 0; t < 30; t++) begin
            logic [3:0] adr, sel;
            logic we;
            logic [31:0] dw;
            adr = 4'($urandom % 10); we = 1'($urandom); sel = 4'($urandom); dw = $urandom;
            run_a(adr, we, sel, dw, dr, kind, st, nacc);
            verify(0, adr, we, sel, dw, dr, kind, st, nacc);
            run_b(adr, we, sel[1:0], dw, dr, kind, st, nacc);
            verify(1, adr, we, beat_mask(2, {2'b00, sel[1:0]}), dw, dr, kind, st, nacc);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule